// File: doc/BRIEF.md
# Conditional execution predicate unit

This block decides, for each instruction entering the first execute stage of a pipelined processor, whether that instruction is allowed to take effect. The top nibble of the 32-bit instruction word names one of five predicate-capable general registers together with a sense bit. The sense bit selects between "execute when the register is zero" and "execute when the register is nonzero". Two nibble patterns are special. The all-zero nibble means the instruction runs unconditionally. The pattern with a zero selector and the sense bit set is reserved as a software breakpoint marker. Selector values 6 and 7 are reserved in every form.

The unit serves a configurable number of issue lanes in parallel, so that the instructions of one execute packet are judged in the same cycle against the same register snapshot. It holds the five predicate registers and has one write port for them. An instruction accepted in a cycle is tested against the register contents as they stood before any write that lands at the end of that cycle. Each lane returns four registered flags: execute-enable, annul, breakpoint and illegal-condition.

Top module: `cond_gate_unit`

## Requirements
- R1: Bits 31:29 of an issue word are the register selector and bit 28 is the sense bit. With sense 1 the condition holds when all 32 bits of the selected register are zero. With sense 0 it holds when any bit of that register is set.
- R2: Selector 000 with sense 0 sets execute-enable for a valid instruction, whatever the register contents.
- R3: Selector 001 tests register B0, 010 tests B1, 011 tests B2, 100 tests A1 and 101 tests A2.
- R4: Selector 000 with sense 1 sets the breakpoint flag and clears execute-enable and annul.
- R5: Selectors 110 and 111, with either sense, set the illegal-condition flag and clear execute-enable and annul.
- R6: Annul is set exactly when a valid instruction with a legal, non-breakpoint encoding has a false condition. For a valid instruction exactly one of the four flags is set.
- R7: The flags for an instruction accepted in cycle N appear in cycle N+1. A lane whose valid strobe is low in cycle N shows all four flags low in cycle N+1.
- R8: The test uses the register value held in the accept cycle. A write at the end of that same cycle is not seen by the test, but it is seen by an instruction accepted in the next cycle.
- R9: A write with the write strobe high and write selector 001 to 101 loads the register named in R3. Write selector 000, 110 or 111 changes no register.
- R10: Two lanes that are valid in the same cycle, test the same register and use opposite sense bits get opposite execute-enable values. Exactly one of them executes.
- R11: While rst_n is low at a clock edge (synchronous, active low), all lane flags and all five predicate registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | LANES | Per-lane instruction valid strobe |
| issue_word | input | LANES x 32 | Per-lane instruction word |
| wr_en | input | 1 | Predicate register write strobe |
| wr_sel | input | 3 | Write target, same code as the condition selector |
| wr_data | input | 32 | Write data |
| ex_en | output | LANES | Execute-enable per lane |
| annul | output | LANES | Condition false, instruction annulled |
| brk_hit | output | LANES | Breakpoint encoding seen |
| bad_cond | output | LANES | Reserved selector seen |

## Verification
The hardest case to reach from the ports is the race between a write and a test of the same register in the same cycle. The R8 rule only shows up when the write changes the outcome of the test. The stimulus therefore loads B0 with a nonzero value, then in a single cycle issues an instruction conditioned on B0 nonzero while writing zero to B0. It expects execute in the next cycle, and then expects an annul when the same instruction is reissued one cycle later. A long random phase mixes same-cycle writes with tests of every register on both lanes, and a cycle-accurate model in the bench tracks the register snapshot.

// File: rtl/cond_pkg.sv
// Package: shared types for the conditional execution predicate unit.
// Assumes a 3-bit selector and one sense bit in the top nibble of each word.
package cond_pkg;
    localparam int SEL_W = 3;
    localparam int NPRED = 5;

    typedef enum logic [1:0] {
        CLS_UNCOND = 2'd0,
        CLS_TEST   = 2'd1,
        CLS_BRK    = 2'd2,
        CLS_BAD    = 2'd3
    } cond_cls_t;

    typedef struct packed {
        cond_cls_t        cls;
        logic [SEL_W-1:0] idx;
        logic             sense;
    } cond_dec_t;
endpackage

// File: rtl/cond_reg_bank.sv
// Predicate register bank: holds the five registers that conditions may test.
// Register k is written by selector code k+1. Other codes write nothing.
// Reads are combinational and show the value held before the current edge.
module cond_reg_bank
    import cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NPRED-1:0][DATA_W-1:0]  rd_vals
);
    for (genvar k = 0; k < NPRED; k++) begin : g_reg
        localparam logic [SEL_W-1:0] CODE = SEL_W'(k + 1);
        logic [DATA_W-1:0] val_q;

        // Load the register on a matching write and clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_sel == CODE)) begin
                val_q <= wr_data;
            end
        end

        assign rd_vals[k] = val_q;
    end
endmodule

// File: rtl/cond_decode.sv
// Condition decoder: classifies the top nibble of an issue word.
// Assumes the nibble is {selector[2:0], sense}. Purely combinational.
module cond_decode
    import cond_pkg::*;
(
    input  logic [SEL_W:0] cond_field,
    output cond_dec_t      dec
);
    logic [SEL_W-1:0] sel;
    logic             sense;

    assign sel   = cond_field[SEL_W:1];
    assign sense = cond_field[0];

    // Map the selector and sense to a class and a register index.
    always_comb begin
        dec.sense = sense;
        dec.idx   = '0;
        if (sel == '0) begin
            dec.cls = sense ? CLS_BRK : CLS_UNCOND;
        end else if (int'(sel) > NPRED) begin
            dec.cls = CLS_BAD;
        end else begin
            dec.cls = CLS_TEST;
            dec.idx = sel - SEL_W'(1);
        end
    end
endmodule

// File: rtl/cond_eval.sv
// Condition evaluator for one lane. It tests the selected register and
// registers the four result flags. Assumes rd_vals is the snapshot from
// before the current edge, so a write at the same edge is not seen.
module cond_eval
    import cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vld,
    input  cond_dec_t                     dec,
    input  logic [NPRED-1:0][DATA_W-1:0]  rd_vals,
    output logic                          ex_q,
    output logic                          annul_q,
    output logic                          brk_q,
    output logic                          bad_q
);
    logic [DATA_W-1:0] picked;
    logic              is_zero;
    logic              cond_true;

    // Select the register named by the decoded index.
    always_comb begin
        picked = '0;
        for (int k = 0; k < NPRED; k++) begin
            if (dec.idx == SEL_W'(k)) begin
                picked = rd_vals[k];
            end
        end
    end

    assign is_zero   = (picked == '0);
    assign cond_true = dec.sense ? is_zero : !is_zero;

    // Register the flags for the accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n || !vld) begin
            ex_q    <= 1'b0;
            annul_q <= 1'b0;
            brk_q   <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            ex_q    <= (dec.cls == CLS_UNCOND) || ((dec.cls == CLS_TEST) && cond_true);
            annul_q <= (dec.cls == CLS_TEST) && !cond_true;
            brk_q   <= (dec.cls == CLS_BRK);
            bad_q   <= (dec.cls == CLS_BAD);
        end
    end
endmodule

// File: rtl/cond_gate_unit.sv
// Top of the predicate unit. One decoder and one evaluator per issue lane
// share a single predicate register bank. Flags are valid one cycle after
// an instruction is accepted.
module cond_gate_unit
    import cond_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int INSN_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LANES-1:0]               issue_vld,
    input  logic [LANES-1:0][INSN_W-1:0]   issue_word,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [LANES-1:0]               ex_en,
    output logic [LANES-1:0]               annul,
    output logic [LANES-1:0]               brk_hit,
    output logic [LANES-1:0]               bad_cond
);
    localparam int FIELD_MSB = INSN_W - 1;

    logic [NPRED-1:0][DATA_W-1:0] rd_vals;

    cond_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_vals (rd_vals)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cond_dec_t dec;

        cond_decode u_dec (
            .cond_field (issue_word[l][FIELD_MSB -: SEL_W+1]),
            .dec        (dec)
        );

        cond_eval #(.DATA_W(DATA_W)) u_eval (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (issue_vld[l]),
            .dec     (dec),
            .rd_vals (rd_vals),
            .ex_q    (ex_en[l]),
            .annul_q (annul[l]),
            .brk_q   (brk_hit[l]),
            .bad_q   (bad_cond[l])
        );
    end
endmodule

// File: rtl/cond_gate_checker.sv
// Checker for cond_gate_unit, attached by bind. It holds only properties
// over the ports and drives nothing.
module cond_gate_checker #(
    parameter int LANES  = 2,
    parameter int INSN_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             issue_vld,
    input logic [LANES-1:0][INSN_W-1:0] issue_word,
    input logic [LANES-1:0]             ex_en,
    input logic [LANES-1:0]             annul,
    input logic [LANES-1:0]             brk_hit,
    input logic [LANES-1:0]             bad_cond
);
    localparam int TOP = INSN_W - 1;

    // R11: reset clears every flag.
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ex_en == '0 && annul == '0 && brk_hit == '0 && bad_cond == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_l
        // R7: an idle lane shows no flag in the next cycle.
        a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !issue_vld[l] |=> !(ex_en[l] || annul[l] || brk_hit[l] || bad_cond[l]));
        // R6: a valid lane shows exactly one flag.
        a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
            issue_vld[l] |=> $countones({ex_en[l], annul[l], brk_hit[l], bad_cond[l]}) == 1);
        // R2: the all-zero nibble always executes.
        a_r2_uncond: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_vld[l] && issue_word[l][TOP -: 4] == 4'b0000) |=> ex_en[l]);
        // R4: the breakpoint nibble raises the breakpoint flag only.
        a_r4_brk: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_vld[l] && issue_word[l][TOP -: 4] == 4'b0001) |=> (brk_hit[l] && !ex_en[l]));
        // R5: reserved selectors raise the illegal flag only.
        a_r5_bad: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_vld[l] && issue_word[l][TOP -: 2] == 2'b11) |=> (bad_cond[l] && !ex_en[l]));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_i
        for (genvar j = i + 1; j < LANES; j++) begin : g_j
            // R10: same register, opposite sense, so exactly one lane executes.
            a_r10_mutex: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_vld[i] && issue_vld[j]
                 && issue_word[i][TOP -: 3] == issue_word[j][TOP -: 3]
                 && issue_word[i][TOP -: 3] != 3'b000
                 && issue_word[i][TOP -: 2] != 2'b11
                 && issue_word[i][TOP-3] != issue_word[j][TOP-3])
                |=> (ex_en[i] != ex_en[j]));
        end
    end
endmodule

bind cond_gate_unit cond_gate_checker #(.LANES(LANES), .INSN_W(INSN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_vld  (issue_vld),
    .issue_word (issue_word),
    .ex_en      (ex_en),
    .annul      (annul),
    .brk_hit    (brk_hit),
    .bad_cond   (bad_cond)
);

// File: tb/sim_cond_gate_unit.sv
`timescale 1ns/1ps
// Bench for cond_gate_unit: a behavioural model predicts each lane's flags
// every cycle and compares them with the design half a cycle later.
module sim_cond_gate_unit;
    localparam int LANES = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        issue_vld = '0;
    logic [LANES-1:0][31:0]  issue_word = '0;
    logic                    wr_en = 1'b0;
    logic [2:0]              wr_sel = '0;
    logic [31:0]             wr_data = '0;
    logic [LANES-1:0]        ex_en, annul, brk_hit, bad_cond;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] mregs [5];
    logic [3:0]  expv [LANES];

    always #2 clk = ~clk;

    cond_gate_unit #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_word(issue_word),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ex_en(ex_en), .annul(annul), .brk_hit(brk_hit), .bad_cond(bad_cond)
    );

    // Model: returns {ex, annul, brk, bad} for one lane.
    function automatic logic [3:0] model(input logic v, input logic [31:0] w);
        int sel;
        logic z;
        logic hit;
        sel = int'(w[31:29]);
        z = w[28];
        if (!v) return 4'b0000;
        if (sel == 0 && !z) return 4'b1000;
        if (sel == 0 && z) return 4'b0010;
        if (sel >= 6) return 4'b0001;
        hit = z ? (mregs[sel-1] == 32'd0) : (mregs[sel-1] != 32'd0);
        return hit ? 4'b1000 : 4'b0100;
    endfunction

    // One clock: predict at the edge, compare at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        for (int l = 0; l < LANES; l++) begin
            expv[l] = rst_n ? model(issue_vld[l], issue_word[l]) : 4'b0000;
        end
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) mregs[k] = '0;
        end else if (wr_en && wr_sel >= 3'd1 && wr_sel <= 3'd5) begin
            mregs[int'(wr_sel) - 1] = wr_data;
        end
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            logic [3:0] got;
            got = {ex_en[l], annul[l], brk_hit[l], bad_cond[l]};
            checks++;
            if (got !== expv[l]) begin
                errors++;
                $display("FAIL %s lane %0d: got %b expected %b", tag, l, got, expv[l]);
            end
        end
    endtask

    task automatic set_lane(input int l, input logic v, input logic [3:0] nib);
        issue_vld[l] = v;
        issue_word[l] = {nib, 28'($urandom)};
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 5; k++) mregs[k] = '0;
        @(negedge clk);
        set_lane(0, 1'b1, 4'b0000);
        step("R11");
        step("R11");
        rst_n = 1'b1;
        issue_vld = '0;
        // R9 / R7: load registers while lanes are idle.
        wr(3'd1, 32'd5, "R9");
        wr(3'd2, 32'd0, "R9");
        wr(3'd3, 32'h8000_0000, "R9");
        wr(3'd4, 32'd1, "R9");
        wr(3'd5, 32'd0, "R7");
        // R2: unconditional.
        set_lane(0, 1'b1, 4'b0000); set_lane(1, 1'b1, 4'b0000);
        step("R2");
        // R3 / R1 / R10: every register, both senses, lanes opposite.
        for (int s = 1; s <= 5; s++) begin
            for (int z = 0; z < 2; z++) begin
                set_lane(0, 1'b1, {3'(s), 1'(z)});
                set_lane(1, 1'b1, {3'(s), 1'(1 - z)});
                step("R3 R1 R10");
            end
        end
        // R4 / R5: breakpoint and reserved selectors.
        set_lane(0, 1'b1, 4'b0001); set_lane(1, 1'b1, 4'b1100);
        step("R4 R5");
        set_lane(0, 1'b1, 4'b1110); set_lane(1, 1'b1, 4'b1111);
        step("R5");
        issue_vld = '0;
        // R9: writes to unused codes change nothing.
        wr(3'd0, 32'd0, "R9");
        wr(3'd6, 32'd0, "R9");
        wr(3'd7, 32'd0, "R9");
        for (int s = 1; s <= 5; s++) begin
            set_lane(0, 1'b1, {3'(s), 1'b0});
            set_lane(1, 1'b1, {3'(s), 1'b1});
            step("R9");
        end
        // R8: a write in the accept cycle is not seen by that test.
        set_lane(0, 1'b1, 4'b0010); set_lane(1, 1'b0, 4'b0000);
        wr(3'd1, 32'd0, "R8");
        step("R8");
        // R1: only the top bit is set in B2, so the zero test fails.
        set_lane(0, 1'b1, 4'b0111); set_lane(1, 1'b1, 4'b0110);
        step("R1");
        // R7: an invalid breakpoint word gives no flags.
        set_lane(0, 1'b0, 4'b0001); set_lane(1, 1'b0, 4'b1110);
        step("R7");
        // R6: random mix of words and writes.
        for (int n = 0; n < 400; n++) begin
            for (int l = 0; l < LANES; l++) begin
                issue_vld[l] = ($urandom % 4) != 0;
                issue_word[l] = $urandom;
            end
            wr_en = ($urandom % 2) == 0;
            wr_sel = 3'($urandom);
            wr_data = (($urandom % 3) == 0) ? 32'd0 : $urandom;
            step("R6");
        end
        wr_en = 1'b0;
        // R11: reset mid-run clears flags and registers.
        set_lane(0, 1'b1, 4'b0010); set_lane(1, 1'b1, 4'b0011);
        rst_n = 1'b0;
        step("R11");
        rst_n = 1'b1;
        set_lane(0, 1'b1, 4'b0011); set_lane(1, 1'b1, 4'b1001);
        step("R11");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule